// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a clocked model of a retriggerable monostable. Three asynchronous control levels go in: an active-low gate, an active-high gate and an active-low clear. A single pulse comes out on a pair of complementary outputs. The pulse length is a number of clock cycles taken from a duration input. That input does the job an external resistor and capacitor would do in an analog one-shot.

A pulse can start in three ways:
- the high gate rises while the low gate is low;
- the low gate falls while the high gate is high;
- clear is released while both gates already sit at their enabling levels.

Any qualifying trigger during a pulse restarts the full duration, so the pulse stretches. A steady stream of triggers therefore holds the output high indefinitely. Holding clear low ends a pulse and blocks every trigger. All three controls pass through a synchroniser and then an edge detector, so a slow or held level produces exactly one trigger per qualifying transition.

Top module: `oneshot_top`

## Requirements
- R1: While reset is high, and after reset with no qualifying transition on the inputs, `pulse` is 0 and `pulse_n` is 1. This holds even when the inputs already sit at enabling levels at reset release.
- R2: A low-to-high change of `gate_hi` while `gate_lo_n` is 0 and `clear_n` is 1 starts a pulse. `pulse` is first seen high after the third rising clock edge that follows the input change.
- R3: A high-to-low change of `gate_lo_n` while `gate_hi` is 1 and `clear_n` is 1 starts a pulse, with the same three-edge latency.
- R4: A low-to-high change of `clear_n` while `gate_lo_n` is 0 and `gate_hi` is 1 starts a pulse, with the same three-edge latency.
- R5: A pulse lasts exactly D clock cycles, where D is the value of `dur_cycles` sampled when the trigger is accepted. Later changes of `dur_cycles` do not alter a pulse already running.
- R6: A qualifying trigger during a pulse reloads the full duration. With D set at that trigger, `pulse` stays high for exactly D+2 cycles after the retriggering input change.
- R7: `clear_n` low forces `pulse` low by the third rising edge after the change. While it stays low, no gate transition starts a pulse.
- R8: A trigger accepted with D = 0 produces no pulse, and it ends any pulse in progress.
- R9: `pulse_n` is the exact complement of `pulse` in every cycle.
- R10: Gate transitions that do not meet a trigger condition, and inputs held at a constant level, never start a pulse.
- R11: Triggers repeated at intervals shorter than D keep `pulse` high without a single low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_lo_n | input | 1 | Asynchronous active-low gate (falling edge triggers) |
| gate_hi | input | 1 | Asynchronous active-high gate (rising edge triggers) |
| clear_n | input | 1 | Asynchronous active-low clear; its release can trigger |
| dur_cycles | input | DUR_W | Pulse length in clock cycles |
| pulse | output | 1 | One-shot output |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The bench measures exact latency and width for each of the three start conditions. A design with a wrong synchroniser depth or an off-by-one counter fails on the cycle count. It also drives transitions that do not qualify, and it releases reset with the inputs already at enabling levels. A design that triggers on levels, or that sees a false edge out of reset, then emits a pulse where none should appear. Further cases are a retrigger in the middle of a pulse, a change of duration during a pulse, a zero duration, and gate activity while clear is low. These catch a design that ignores retriggers, reads the duration continuously, or lets clear be overridden. A long constrained-random run compares both outputs against a cycle model computed in the bench.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

   // synchronised control levels
   typedef struct packed {
      logic lo_n;   // active-low gate
      logic hi;     // active-high gate
      logic clr_n;  // active-low clear
   } ctl_t;

   localparam int CTL_W = 3;

   // levels that can never form a trigger edge from reset:
   // a low gate cannot fall, a high gate cannot rise, a high clear cannot rise
   localparam ctl_t CTL_QUIET = '{lo_n: 1'b0, hi: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
   parameter int              W      = 3,
   parameter int              STAGES = 2,
   parameter logic [W-1:0]    RST_V  = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("oneshot_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("oneshot_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= {STAGES{RST_V}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[LAST];

endmodule

// File: rtl/oneshot_qual.sv
module oneshot_qual
   import oneshot_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  ctl_t cur,
   output logic fire
);

   ctl_t prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= CTL_QUIET;
      else     prev <= cur;
   end

   logic hi_rise, lo_fall, clr_rise;

   always_comb begin
      hi_rise  = cur.hi    & ~prev.hi;
      lo_fall  = ~cur.lo_n & prev.lo_n;
      clr_rise = cur.clr_n & ~prev.clr_n;
      fire     = cur.clr_n & ~cur.lo_n & (hi_rise | (lo_fall & cur.hi) | (clr_rise & cur.hi));
   end

   // R10: a trigger always needs some input to have changed
   a_r10_edge_needed: assert property (@(posedge clk) disable iff (rst)
      fire |-> (cur != prev));

   // R7: no trigger while clear is held low
   a_r7_blocked: assert property (@(posedge clk) disable iff (rst)
      (!cur.clr_n && !prev.clr_n) |-> !fire);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int DUR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fire,
   input  logic             clr_lvl_n,
   input  logic [DUR_W-1:0] dur,
   output logic             q,
   output logic             qn
);

   localparam logic [DUR_W-1:0] ZERO = '0;
   localparam logic [DUR_W-1:0] ONE  = {{(DUR_W-1){1'b0}}, 1'b1};

   generate
      if (DUR_W < 1 || DUR_W > 32) begin : g_bad_dur
         $error("oneshot_timer: DUR_W must be 1..32");
      end
   endgenerate

   logic [DUR_W-1:0] cnt, cnt_nx;

   always_comb begin
      if (!clr_lvl_n)        cnt_nx = ZERO;
      else if (fire)         cnt_nx = dur;
      else if (cnt != ZERO)  cnt_nx = cnt - ONE;
      else                   cnt_nx = ZERO;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= ZERO;
         q   <= 1'b0;
         qn  <= 1'b1;
      end else begin
         cnt <= cnt_nx;
         q   <= (cnt_nx != ZERO);
         qn  <= (cnt_nx == ZERO);
      end
   end

   // R1: reset forces idle outputs
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!q && qn));

   // R9: outputs stay complementary
   a_r9_complement: assert property (@(posedge clk) disable iff (rst)
      q != qn);

   // R7: clear ends the pulse
   a_r7_clear_ends: assert property (@(posedge clk) disable iff (rst)
      !clr_lvl_n |=> !q);

   // R6: accepted trigger reloads the full duration
   a_r6_reload: assert property (@(posedge clk) disable iff (rst)
      (fire && clr_lvl_n) |=> (cnt == $past(dur)));

   // R8: zero duration yields no pulse
   a_r8_zero: assert property (@(posedge clk) disable iff (rst)
      (fire && clr_lvl_n && dur == ZERO) |=> !q);

   // R5: running pulse counts down by one per cycle
   a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
      (clr_lvl_n && !fire && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/oneshot_top.sv
module oneshot_top
   import oneshot_pkg::*;
#(
   parameter int DUR_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gate_lo_n,
   input  logic             gate_hi,
   input  logic             clear_n,
   input  logic [DUR_W-1:0] dur_cycles,
   output logic             pulse,
   output logic             pulse_n
);

   ctl_t raw, synced;
   logic fire;
   logic [CTL_W-1:0] synced_bits;

   assign raw = '{lo_n: gate_lo_n, hi: gate_hi, clr_n: clear_n};

   oneshot_sync #(
      .W      (CTL_W),
      .STAGES (SYNC_STAGES),
      .RST_V  (CTL_QUIET)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (synced_bits)
   );

   assign synced = ctl_t'(synced_bits);

   oneshot_qual u_qual (
      .clk  (clk),
      .rst  (rst),
      .cur  (synced),
      .fire (fire)
   );

   oneshot_timer #(.DUR_W(DUR_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .fire      (fire),
      .clr_lvl_n (synced.clr_n),
      .dur       (dur_cycles),
      .q         (pulse),
      .qn        (pulse_n)
   );

endmodule

// File: tb/tb_oneshot_top.sv
module tb_oneshot_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic lo_n = 1'b0, hi = 1'b1, clr_n = 1'b1;
   logic [DW-1:0] dur = 8'd5;
   logic q, qn;

   int checks = 0, errors = 0;
   logic done = 1'b0;
   logic model_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   oneshot_top #(.DUR_W(DW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst(rst), .gate_lo_n(lo_n), .gate_hi(hi), .clear_n(clr_n),
      .dur_cycles(dur), .pulse(q), .pulse_n(qn)
   );

   // ---------------- bench reference model (from requirements) ----------
   logic [2:0] m_s1, m_s2, m_pv;   // {lo_n, hi, clr_n}
   int m_cnt;

   function automatic logic m_fire(logic [2:0] c, logic [2:0] p);
      logic rise_hi, fall_lo, rise_clr;
      rise_hi  = c[1] && !p[1];
      fall_lo  = !c[2] && p[2];
      rise_clr = c[0] && !p[0];
      return c[0] && ((rise_hi && !c[2]) || (fall_lo && c[1]) || (rise_clr && !c[2] && c[1]));
   endfunction

   function automatic int m_next(int cnt, logic [2:0] c, logic [2:0] p, int d);
      if (!c[0])            return 0;
      if (m_fire(c, p))     return d;
      if (cnt > 0)          return cnt - 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_s1 <= 3'b011; m_s2 <= 3'b011; m_pv <= 3'b011; m_cnt <= 0;
      end else begin
         m_s1  <= {lo_n, hi, clr_n};
         m_s2  <= m_s1;
         m_pv  <= m_s2;
         m_cnt <= m_next(m_cnt, m_s2, m_pv, int'(dur));
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // after an input change just made at a negedge: edges until pulse high
   task automatic lat_width(output int lat, output int wid);
      lat = 0; wid = 0;
      for (int i = 0; i < 20 && !q; i++) begin @(negedge clk); lat++; end
      for (int i = 0; i < 300 && q; i++) begin @(negedge clk); wid++; end
   endtask

   task automatic count_high(int n, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (q) hits++; end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lat, wid, hits;
      void'($urandom(32'h51C0));

      // R1: reset with inputs already at enabling levels
      idle(3);
      chk("R1 q in reset", int'(q), 0);
      chk("R1 qn in reset", int'(qn), 1);
      rst = 1'b0;
      count_high(12, hits);
      chk("R1 no spurious pulse", hits, 0);
      chk("R9 qn idle", int'(qn), 1);

      // R2: high gate rises, low gate low
      hi = 1'b0; idle(5);
      dur = 8'd5; hi = 1'b1;
      lat_width(lat, wid);
      chk("R2 latency", lat, 3);
      chk("R5 width 5", wid, 5);

      // R3: low gate falls, high gate high
      lo_n = 1'b1; idle(5);
      dur = 8'd7; lo_n = 1'b0;
      lat_width(lat, wid);
      chk("R3 latency", lat, 3);
      chk("R5 width 7", wid, 7);

      // R4: clear released with gates enabling
      clr_n = 1'b0; idle(5);
      dur = 8'd3; clr_n = 1'b1;
      lat_width(lat, wid);
      chk("R4 latency", lat, 3);
      chk("R4 width 3", wid, 3);

      // R10: non-qualifying transitions and held levels
      lo_n = 1'b1; idle(4);
      hi = 1'b0; idle(4);
      hi = 1'b1; idle(4);          // rises while low gate high
      hi = 1'b0; idle(4);
      lo_n = 1'b0; idle(2);        // falls while high gate low
      count_high(12, hits);
      chk("R10 no pulse", hits, 0);

      // R5: duration change during a pulse has no effect
      dur = 8'd4; hi = 1'b1;
      idle(4);
      dur = 8'd40;
      idle(1);
      wid = 2;                     // q high at the 3rd and 4th negedge
      for (int i = 0; i < 60 && q; i++) begin @(negedge clk); wid++; end
      chk("R5 width kept", wid, 4);

      // R6: retrigger mid pulse
      hi = 1'b0; dur = 8'd10; idle(3);
      hi = 1'b1; idle(3);           // pulse starts
      idle(5);
      hi = 1'b0; idle(1);
      dur = 8'd10; hi = 1'b1;       // retrigger
      wid = 0;
      for (int i = 0; i < 60 && q; i++) begin @(negedge clk); if (q) wid++; end
      chk("R6 stretched", wid, 12);

      // R7: clear ends a pulse and blocks triggers
      hi = 1'b0; dur = 8'd30; idle(3);
      hi = 1'b1; idle(6);
      clr_n = 1'b0;
      idle(2);
      chk("R7 still high before sync", int'(q), 1);
      idle(1);
      chk("R7 cleared", int'(q), 0);
      chk("R9 qn after clear", int'(qn), 1);
      hi = 1'b0; idle(3); hi = 1'b1; idle(3);
      lo_n = 1'b1; idle(3); lo_n = 1'b0;
      count_high(8, hits);
      chk("R7 blocked", hits, 0);
      lo_n = 1'b1; idle(3);
      clr_n = 1'b1;                 // release without enabling gates
      count_high(8, hits);
      chk("R10 clear release gated", hits, 0);

      // R8: zero duration, and zero retrigger ends a pulse
      lo_n = 1'b0; hi = 1'b0; idle(3);
      dur = 8'd0; hi = 1'b1;
      count_high(10, hits);
      chk("R8 zero no pulse", hits, 0);
      hi = 1'b0; dur = 8'd20; idle(3);
      hi = 1'b1; idle(5);
      hi = 1'b0; idle(1);
      dur = 8'd0; hi = 1'b1;
      idle(3);
      chk("R8 zero ends pulse", int'(q), 0);

      // R11: fast retriggering holds q high
      hi = 1'b0; dur = 8'd6; idle(3);
      hi = 1'b1; idle(3);
      hits = 0;
      for (int k = 0; k < 10; k++) begin
         hi = 1'b0; @(negedge clk); if (q) hits++;
         hi = 1'b1; @(negedge clk); if (q) hits++;
         @(negedge clk); if (q) hits++;
         @(negedge clk); if (q) hits++;
      end
      chk("R11 continuous", hits, 40);
      hi = 1'b0; idle(12);

      // random phase against the bench model (R2..R11 combined)
      model_on = 1'b1;
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         chk("R5 random q vs model", int'(q), int'(m_cnt > 0));
         chk("R9 random complement", int'(qn), int'(!q));
         if ($urandom_range(3) == 0) lo_n = ~lo_n;
         if ($urandom_range(3) == 0) hi = ~hi;
         if ($urandom_range(11) == 0) clr_n = ~clr_n;
         if ($urandom_range(7) == 0) dur = DW'($urandom_range(12));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule